// File: doc/BRIEF.md
# Glitch-Free Card Clock Selector

This block produces the clock driven to one card slot. It chooses among four sources: a constant low level, a constant high level, an external input clock divided by a programmable ratio, and a free-running internal oscillator clock. Both incoming clocks are sampled by a fast system clock. All switching happens in that clock domain, and the output is a registered level. An 8-bit settings word, written through a simple strobe-and-data port, carries the mode bits and the ratio field. The block refuses mode moves that are not on its list of allowed transitions. Allowed moves are delayed until a safe moment, so the card never sees a shortened pulse.

A status output goes high once the internal oscillator is really the source of the card clock. This does not happen at the moment it is requested. An activation input keeps the slot on the divided clock while internal mode is selected, and the internal clock takes over once activation ends. A synchronous-mode input bypasses all of this protection. In that mode the output is either the sampled input clock, switched at once, or a level taken directly from one settings bit.

Top module: `card_clk_sel`

## Requirements
- R1: After a synchronous active-low reset the card clock is 0, the internal-clock status is 0, and the settings readback is 0x20 (static low, ratio code 000, spare bits 00).
- R2: Settings layout: bit 7 selects internal clock, bit 6 selects static high, bit 5 selects static low, and bits [7:5] = 000 selects the divided clock. Priority is 7 over 6 over 5. Bits [4:2] hold the ratio code and bits [1:0] are spare storage. The readback returns the stored word. In static high the output is 1; in static low it is 0.
- R3: Ratio codes 000, 001, 010, 011 and 100 divide the input clock by 1, 2, 4, 5 and 8. Codes 101 to 111 divide by 8. The output period is the ratio times the input period.
- R4: Ratios 2, 4 and 8 give a high time of exactly half the output period. Ratio 1 reproduces the input high time. Ratio 5 gives a high time of two input periods plus one input high time.
- R5: A write with any of bits [7:5] set leaves the stored ratio code unchanged.
- R6: Outside synchronous mode, only these moves are allowed: divided to static low, static high or internal, and any of those three back to divided. Any other mode write is ignored as a whole: the readback and the output are unchanged.
- R7: A move between the divided clock and a static level happens only while the divided clock equals that level. No output pulse is ever shorter than the shortest pulse of the source it came from.
- R8: A new ratio takes effect only at the next rising edge of the divided clock. The period in progress completes at the old ratio.
- R9: A move between divided and internal happens only in a system-clock cycle in which both clocks rise. From then on the output follows the internal clock, and the status output is 1.
- R10: The status output is 0 whenever the output is not taken from the internal clock.
- R11: While the activation input is 1 and internal mode is selected, the output stays on the divided clock and the status stays 0. When activation ends, the move to internal follows R9.
- R12: In synchronous mode with sync-enable 1, the output equals the input clock as sampled SYNC_STAGES+1 system-clock edges earlier, with no alignment.
- R13: In synchronous mode with sync-enable 0, settings bit 6 sets the output level directly. Low and high may follow each other directly, with no refusal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than both sampled clocks |
| rstN | input | 1 | Synchronous active-low reset |
| extClk | input | 1 | External input clock to be divided |
| intClk | input | 1 | Internal oscillator clock |
| wrEn | input | 1 | Settings write strobe |
| wrData | input | 8 | Settings write data |
| actActive | input | 1 | Activation phase in progress |
| syncMode | input | 1 | Synchronous card mode |
| syncEn | input | 1 | In synchronous mode, route the input clock straight to the output |
| settings | output | 8 | Stored settings word |
| cardClk | output | 1 | Card clock output |
| clkSw | output | 1 | Internal clock is driving the output |

## Verification
The bench sweeps every ratio code under two input duty cycles and measures period and high time. A divider that miscounted the odd ratio, or that ignored input duty at ratio 1, would show the wrong widths. A ratio change is issued just after a divided rising edge, and a move to static high just after a falling edge. A design that switched on the write instead of at the safe point would cut the pulse in progress, and both the measured width and a runt-pulse monitor would catch it. Every refused move and a ratio write carrying mode bits are checked at the readback and at the output. The activation hold, the coincident-edge handover to the internal clock and the unprotected synchronous path each have their own checks; the synchronous path is compared cycle by cycle against a delayed copy of the input.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  localparam int RATIO_W = 3;
  localparam int CNT_W   = 3;
  localparam int DIV_W   = 4;

  typedef enum logic [1:0] {MD_LOW, MD_HIGH, MD_DIV, MD_INT} mode_e;
  typedef enum logic [2:0] {SRC_LOW, SRC_HIGH, SRC_DIV, SRC_INT, SRC_EXT} src_e;

  // strobes from control to datapath
  typedef struct packed {
    src_e               src;
    logic [RATIO_W-1:0] ratioReq;
  } dp_cmd_t;

  // observations from datapath to control
  typedef struct packed {
    logic divLvl;
    logic divRise;
    logic intRise;
  } dp_stat_t;

  function automatic mode_e decodeMode(input logic [2:0] bits);
    if (bits[2])      return MD_INT;
    else if (bits[1]) return MD_HIGH;
    else if (bits[0]) return MD_LOW;
    else              return MD_DIV;
  endfunction

  // divided mode is the hub: every allowed move enters or leaves it
  function automatic logic isPermitted(input mode_e fromM, input mode_e toM);
    return (fromM == MD_DIV && toM != MD_DIV) || (fromM != MD_DIV && toM == MD_DIV);
  endfunction

  function automatic logic [DIV_W-1:0] divisorOf(input logic [RATIO_W-1:0] code);
    case (code)
      3'd0:    return DIV_W'(1);
      3'd1:    return DIV_W'(2);
      3'd2:    return DIV_W'(4);
      3'd3:    return DIV_W'(5);
      default: return DIV_W'(8);
    endcase
  endfunction

  function automatic src_e srcOf(input mode_e m);
    case (m)
      MD_HIGH: return SRC_HIGH;
      MD_DIV:  return SRC_DIV;
      MD_INT:  return SRC_INT;
      default: return SRC_LOW;
    endcase
  endfunction

endpackage

// File: rtl/cardclk_sync.sv
module cardclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] shReg;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) shReg <= '0;
        else       shReg <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) shReg <= '0;
        else       shReg <= {shReg[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = shReg[STAGES-1];

endmodule

// File: rtl/cardclk_dpath.sv
module cardclk_dpath
  import cardclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     extClk,
  input  logic     intClk,
  input  dp_cmd_t  cmd,
  output dp_stat_t stat,
  output logic     cardClk,
  output logic     clkSw
);

  logic extS, intS;
  logic extPrev, intPrev, intPrev2, divPrev;
  logic [RATIO_W-1:0] ratioAct;
  logic [CNT_W-1:0]   cnt;
  logic [DIV_W-1:0]   divisor, halfDiv, cntX, lastCnt;
  logic extRise, wrap, divClk, srcLvl;

  cardclk_sync #(.STAGES(SYNC_STAGES)) u_extSync (
    .clk(clk), .rstN(rstN), .din(extClk), .dout(extS)
  );
  cardclk_sync #(.STAGES(SYNC_STAGES)) u_intSync (
    .clk(clk), .rstN(rstN), .din(intClk), .dout(intS)
  );

  always_comb begin
    divisor = divisorOf(ratioAct);
    halfDiv = divisor >> 1;
    lastCnt = divisor - DIV_W'(1);
    cntX    = DIV_W'(cnt);
    extRise = extS & ~extPrev;
    wrap    = extRise && (cntX >= lastCnt);
    // odd ratios stretch the middle input period by its own high phase
    if (divisor[0]) divClk = (cntX < halfDiv) || ((cntX == halfDiv) && extPrev);
    else            divClk = (cntX < halfDiv);
  end

  always_comb begin
    case (cmd.src)
      SRC_HIGH: srcLvl = 1'b1;
      SRC_DIV:  srcLvl = divClk;
      SRC_INT:  srcLvl = intPrev;
      SRC_EXT:  srcLvl = extPrev;
      default:  srcLvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      extPrev  <= 1'b0;
      intPrev  <= 1'b0;
      intPrev2 <= 1'b0;
      divPrev  <= 1'b0;
      cnt      <= '0;
      ratioAct <= '0;
      cardClk  <= 1'b0;
      clkSw    <= 1'b0;
    end else begin
      extPrev  <= extS;
      intPrev  <= intS;
      intPrev2 <= intPrev;
      divPrev  <= divClk;
      if (extRise) begin
        if (wrap) begin
          cnt      <= '0;
          ratioAct <= cmd.ratioReq;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
      cardClk <= srcLvl;
      clkSw   <= (cmd.src == SRC_INT);
    end
  end

  always_comb begin
    stat.divLvl  = divClk;
    stat.divRise = divClk & ~divPrev;
    stat.intRise = intPrev & ~intPrev2;
  end

  // R8: the active ratio only moves on an input edge that restarts the divided period
  p_ratio_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ratioAct != $past(ratioAct)) |-> $past(extRise) && (cnt == '0));

  // R3: the phase counter never runs past the active ratio
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    DIV_W'(cnt) < divisorOf(ratioAct));

  // R10: status only while the internal clock was the selected source
  p_clksw_src_r10: assert property (@(posedge clk) disable iff (!rstN)
    clkSw |-> $past(cmd.src) == SRC_INT);

endmodule

// File: rtl/cardclk_ctrl.sv
module cardclk_ctrl
  import cardclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       actActive,
  input  logic       syncMode,
  input  logic       syncEn,
  input  dp_stat_t   stat,
  output dp_cmd_t    cmd,
  output logic [7:0] settings
);

  logic [2:0]         regMode;
  logic [RATIO_W-1:0] regRatio;
  logic [1:0]         regSpare;
  mode_e curMode, curNext, tgtMode, wrMode;
  logic  wrAccept, coincide;

  always_comb begin
    wrMode   = decodeMode(wrData[7:5]);
    wrAccept = syncMode || (wrMode == curMode) || isPermitted(curMode, wrMode);
    tgtMode  = decodeMode(regMode);
    if (tgtMode == MD_INT && actActive) tgtMode = MD_DIV;
    coincide = stat.intRise && stat.divRise;
  end

  always_comb begin
    curNext = curMode;
    if (syncMode) begin
      curNext = tgtMode;
    end else if (tgtMode != curMode) begin
      case (curMode)
        MD_LOW:  if (tgtMode == MD_DIV && !stat.divLvl) curNext = MD_DIV;
        MD_HIGH: if (tgtMode == MD_DIV &&  stat.divLvl) curNext = MD_DIV;
        MD_INT:  if (tgtMode == MD_DIV && coincide)     curNext = MD_DIV;
        default: begin
          case (tgtMode)
            MD_LOW:  if (!stat.divLvl) curNext = MD_LOW;
            MD_HIGH: if (stat.divLvl)  curNext = MD_HIGH;
            MD_INT:  if (coincide)     curNext = MD_INT;
            default: curNext = curMode;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regMode  <= 3'b001;
      regRatio <= '0;
      regSpare <= '0;
      curMode  <= MD_LOW;
    end else begin
      if (wrEn && wrAccept) begin
        regMode  <= wrData[7:5];
        regSpare <= wrData[1:0];
        if (wrData[7:5] == 3'b000) regRatio <= wrData[4:2];
      end
      curMode <= curNext;
    end
  end

  // the source follows the next state so the mux flips in the aligned cycle itself
  always_comb begin
    if (syncMode) cmd.src = syncEn ? SRC_EXT : (regMode[1] ? SRC_HIGH : SRC_LOW);
    else          cmd.src = srcOf(curNext);
    cmd.ratioReq = regRatio;
    settings     = {regMode, regRatio, regSpare};
  end

  // R6: outside sync mode the active mode only takes allowed steps
  p_perm_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(syncMode) && curMode != $past(curMode)) |-> isPermitted($past(curMode), curMode));

  // R6: a refused write leaves the stored word alone
  p_refuse_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !syncMode && decodeMode(wrData[7:5]) != curMode
     && !isPermitted(curMode, decodeMode(wrData[7:5]))) |=> $stable(settings));

  // R5: ratio field locked when a mode bit is written
  p_ratio_lock_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[7:5] != 3'b000) |=> $stable(regRatio));

  // R7: leaving or entering a static level only while the divided clock sits at it
  p_static_align_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(syncMode) && $past(curMode) == MD_DIV && curMode == MD_HIGH) |-> $past(stat.divLvl));
  p_static_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(syncMode) && $past(curMode) == MD_LOW && curMode == MD_DIV) |-> !$past(stat.divLvl));

  // R9: handover to the internal clock on coincident rising edges only
  p_int_align_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(syncMode) && $past(curMode) == MD_DIV && curMode == MD_INT)
      |-> $past(stat.intRise && stat.divRise));

  // R11: activation keeps the internal clock away
  p_act_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (actActive && !syncMode && curMode != MD_INT) |=> curMode != MD_INT);

endmodule

// File: rtl/card_clk_sel.sv
module card_clk_sel
  import cardclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       extClk,
  input  logic       intClk,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       actActive,
  input  logic       syncMode,
  input  logic       syncEn,
  output logic [7:0] settings,
  output logic       cardClk,
  output logic       clkSw
);

  dp_cmd_t  cmd;
  dp_stat_t stat;

  cardclk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .actActive(actActive), .syncMode(syncMode), .syncEn(syncEn),
    .stat(stat), .cmd(cmd), .settings(settings)
  );

  cardclk_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .extClk(extClk), .intClk(intClk),
    .cmd(cmd), .stat(stat), .cardClk(cardClk), .clkSw(clkSw)
  );

  // R10: status never outlives a reset
  p_reset_state_r1: assert property (@(posedge clk)
    $past(!rstN) |-> !clkSw && !cardClk);

endmodule

// File: tb/sim_card_clk_sel.sv
module sim_card_clk_sel;

  localparam int CLK_PERIOD = 10;
  localparam int MIN_RUN    = 2;
  localparam int TIMEOUT    = 150000;
  localparam int INT_PER    = 4;
  localparam int INT_HI     = 2;

  logic clk = 1'b0;
  logic rstN, extClk, intClk, wrEn, actActive, syncMode, syncEn;
  logic [7:0] wrData, settings;
  logic cardClk, clkSw;

  int checks = 0, fails = 0, cyc = 0, t = 0;
  int extPer = 8, extHi = 3;
  logic [7:0] extHist = '0;
  bit monEn = 0;
  logic lastLvl = 1'b0;
  int runLen = 0;

  card_clk_sel u0 (
    .clk(clk), .rstN(rstN), .extClk(extClk), .intClk(intClk),
    .wrEn(wrEn), .wrData(wrData), .actActive(actActive),
    .syncMode(syncMode), .syncEn(syncEn), .settings(settings),
    .cardClk(cardClk), .clkSw(clkSw)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // source clocks change at the falling edge, away from sampling
  always @(negedge clk) begin
    t = t + 1;
    extClk = (t % extPer) < extHi;
    intClk = (t % INT_PER) < INT_HI;
  end

  always @(posedge clk) extHist <= {extHist[6:0], extClk};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // R7: runt pulse monitor
  always @(negedge clk) begin
    if (cardClk === lastLvl) runLen++;
    else begin
      if (monEn && runLen < MIN_RUN) chk(0, "R7 runt pulse width", runLen, MIN_RUN);
      runLen  = 1;
      lastLvl = cardClk;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > TIMEOUT) begin
      chk(0, "watchdog R1..R13", cyc, TIMEOUT);
      summary();
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] d);
    wrEn = 1'b1; wrData = d; tick(1); wrEn = 1'b0;
  endtask

  task automatic measure(output int hi, output int per);
    int g = 0, lo = 0;
    hi = 0;
    while (cardClk && g < 3000) begin g++; tick(1); end
    while (!cardClk && g < 3000) begin g++; tick(1); end
    while (cardClk && g < 3000) begin g++; hi++; tick(1); end
    while (!cardClk && g < 3000) begin g++; lo++; tick(1); end
    per = (g >= 3000) ? -1 : hi + lo;
  endtask

  function automatic int expDiv(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 5;
      default: return 8;
    endcase
  endfunction

  function automatic int expHigh(input int code);
    int n = expDiv(code);
    if (n == 1) return extHi;
    if (n == 5) return 2 * extPer + extHi;
    return n * extPer / 2;
  endfunction

  task automatic setDuty(input int hi);
    while ((t % extPer) != extPer - 1) tick(1);
    extHi = hi;
  endtask

  task automatic countLevel(input int n, input logic lvl, output int bad);
    bad = 0;
    repeat (n) begin if (cardClk !== lvl) bad++; tick(1); end
  endtask

  task automatic waitSw(input logic lvl, output int waited);
    waited = 0;
    while (clkSw !== lvl && waited < 1000) begin waited++; tick(1); end
  endtask

  initial begin
    int hi, per, bad, w;
    rstN = 0; wrEn = 0; wrData = '0; actActive = 0; syncMode = 0; syncEn = 0;
    tick(5);
    rstN = 1;
    tick(2);
    // R1 reset state
    chk(cardClk == 1'b0, "R1 cardClk", cardClk, 0);
    chk(clkSw == 1'b0, "R1 clkSw", clkSw, 0);
    chk(settings == 8'h20, "R1 settings", settings, 8'h20);
    monEn = 1;

    // R6 refused moves from static low; R2 low level
    wr(8'h40); countLevel(40, 1'b0, bad);
    chk(bad == 0, "R6 low->high output", bad, 0);
    chk(settings == 8'h20, "R6 low->high settings", settings, 8'h20);
    wr(8'h80); countLevel(40, 1'b0, bad);
    chk(bad == 0 && clkSw == 0, "R6 low->int output", bad, 0);
    chk(settings == 8'h20, "R6 low->int settings", settings, 8'h20);

    // R3 R4 sweep over every ratio code, two input duties
    for (int d = 0; d < 2; d++) begin
      setDuty(d == 0 ? 3 : 5);
      for (int code = 0; code < 8; code++) begin
        wr(8'(code << 2));
        measure(hi, per); measure(hi, per);
        chk(per == expDiv(code) * extPer, $sformatf("R3 period code %0d", code), per, expDiv(code) * extPer);
        chk(hi == expHigh(code), $sformatf("R4 high time code %0d", code), hi, expHigh(code));
      end
    end
    setDuty(3);
    chk(settings == 8'h1C, "R2 divided readback", settings, 8'h1C);

    // R8 ratio change /8 -> /2 just after a divided rising edge
    wr(8'h10); measure(hi, per); measure(hi, per);
    while (cardClk) tick(1);
    while (!cardClk) tick(1);
    hi = 1; wr(8'h04);
    while (cardClk) begin hi++; tick(1); end
    per = 0;
    while (!cardClk) begin per++; tick(1); end
    chk(hi == 32, "R8 old high kept", hi, 32);
    chk(per == 32, "R8 old low kept", per, 32);
    hi = 0;
    while (cardClk) begin hi++; tick(1); end
    chk(hi == 8, "R8 new ratio high", hi, 8);

    // R7 divided -> static high just after a falling edge
    wr(8'h10); measure(hi, per); measure(hi, per);
    while (!cardClk) tick(1);
    while (cardClk) tick(1);
    per = 1; wr(8'h40);
    while (!cardClk && per < 200) begin per++; tick(1); end
    chk(per == 32, "R7 low pulse completes", per, 32);
    countLevel(200, 1'b1, bad);
    chk(bad == 0, "R7 R2 held high", bad, 0);
    chk(settings == 8'h50, "R2 high readback", settings, 8'h50);

    // R6 refused moves from static high
    wr(8'h20); countLevel(40, 1'b1, bad);
    chk(bad == 0 && settings == 8'h50, "R6 high->low", settings, 8'h50);
    wr(8'h80); countLevel(40, 1'b1, bad);
    chk(bad == 0 && settings == 8'h50 && clkSw == 0, "R6 high->int", settings, 8'h50);

    // R5 ratio locked while a mode bit is written
    wr(8'h04); tick(100);
    wr(8'h2C);
    chk(settings == 8'h24, "R5 ratio field ignored", settings, 8'h24);
    tick(100); countLevel(40, 1'b0, bad);
    chk(bad == 0, "R5 R7 settles low", bad, 0);

    // R11 activation holds the divided clock
    wr(8'h04); tick(100);
    actActive = 1;
    wr(8'h80);
    chk(settings == 8'h84, "R11 internal accepted", settings, 8'h84);
    bad = 0;
    repeat (200) begin if (clkSw) bad++; tick(1); end
    chk(bad == 0, "R11 status stays 0", bad, 0);
    measure(hi, per);
    chk(per == 16 && hi == 8, "R11 divided during activation", per, 16);

    // R9 handover after activation ends
    actActive = 0;
    waitSw(1'b1, w);
    chk(clkSw == 1'b1, "R9 status rises", w, 0);
    measure(hi, per);
    chk(per == INT_PER && hi == INT_HI, "R9 internal period", per, INT_PER);

    // R6 refused moves from internal
    wr(8'h20); wr(8'h40); tick(40);
    chk(settings == 8'h84 && clkSw == 1, "R6 int->static refused", settings, 8'h84);
    measure(hi, per);
    chk(per == INT_PER, "R6 int clock kept", per, INT_PER);

    // R10 back to divided clears the status
    wr(8'h04);
    waitSw(1'b0, w);
    tick(20);
    chk(clkSw == 1'b0, "R10 status cleared", clkSw, 0);
    measure(hi, per);
    chk(per == 16, "R10 divided period", per, 16);

    // R12 synchronous bypass
    monEn = 0;
    syncMode = 1; syncEn = 1;
    tick(8);
    bad = 0;
    repeat (96) begin if (cardClk !== extHist[3]) bad++; tick(1); end
    chk(bad == 0, "R12 raw input follows", bad, 0);

    // R13 direct static levels in sync mode
    syncEn = 0;
    wr(8'h40); tick(3);
    chk(cardClk == 1'b1, "R13 level high", cardClk, 1);
    wr(8'h20); tick(3);
    chk(cardClk == 1'b0, "R13 low from high", cardClk, 0);
    chk(settings == 8'h24, "R13 settings low", settings, 8'h24);
    wr(8'h40); tick(3);
    chk(cardClk == 1'b1, "R13 high from low", cardClk, 1);
    syncMode = 0;
    countLevel(50, 1'b1, bad);
    chk(bad == 0, "R13 exit keeps high", bad, 0);
    monEn = 1;
    tick(20);
    summary();
  end

endmodule